// File: doc/BRIEF.md
# Smart Mailbox Interrupt Array

This block is an array of 64-bit mailbox words behind a simple register port. Each word can raise its own interrupt when it is written. Every mailbox carries its own configuration.

- An input mode decides how an incoming write combines with the stored word: replace it, OR into it, or add to it.
- A trigger condition is checked on the updated word to decide whether the write raises that mailbox's interrupt.
- A trigger sets a sticky pending bit, which drives that mailbox's interrupt line.
- Software clears the pending bit by writing the mailbox index to an acknowledge location.

Producers signal a consumer by writing a word, so the memory acts as the interrupt source. Typical uses:

- **Doorbell:** any write fires.
- **Match:** fires on a counted handshake that reaches a set value.
- **Barrier:** works like match, and the word clears to zero when it fires, so the barrier can be reused.
- **Threshold:** fires when the word reaches or passes a level.

The port always accepts a request. A write takes effect in the cycle it is presented. A read returns its data one cycle later.

Top module: `mbox_irq_array`

## Requirements
- R1: After reset every mailbox word, configuration field and trigger value reads as zero, and every interrupt line is low.
- R2: Address bits [IDX_W+1:IDX_W] select a region: 0 mailbox word, 1 configuration, 2 trigger value, 3 acknowledge. The low IDX_W bits select the mailbox. A configuration word keeps the mode in bits [1:0] and the condition in bits [3:2]. Reads of the acknowledge region return zero.
- R3: With mode code 00 (and with the unused code 11), a mailbox write replaces the stored word.
- R4: With mode code 01, a mailbox write ORs the data into the stored word.
- R5: With mode code 10, a mailbox write adds the data to the stored word, modulo 2^64.
- R6: With condition code 00 (doorbell), every mailbox write raises that mailbox's interrupt.
- R7: With condition code 01 (match), the interrupt is raised only when the updated word equals the trigger value.
- R8: With condition code 10 (barrier), the trigger behaves as match, and the stored word becomes zero when it fires. Otherwise the updated word is kept.
- R9: With condition code 11 (threshold), the interrupt is raised when the updated word, compared unsigned, is greater than or equal to the trigger value.
- R10: Pending bits are sticky, and the interrupt line is high from the clock edge after the triggering write. Writing index k to the acknowledge region clears bit k alone. Writes to the configuration, trigger or acknowledge regions never raise an interrupt.
- R11: A read yields rd_valid and the data one cycle after the request, with no side effects. Back-to-back writes to one mailbox accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W+2 | Region and mailbox index |
| bus_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| irq | output | NUM_MBOX | Per-mailbox pending interrupt level |

## Verification
The timing of each result is fixed:

- A mailbox write updates the stored word and, if the trigger condition holds, the interrupt line at the next rising edge.
- An acknowledge clears its line at that same edge.
- Read data and rd_valid appear one edge after the request.

The bench drives every request on a falling edge and checks the whole interrupt vector and any read data on the following falling edge, one register stage later. It compares against a model updated in the same order: combine, compare, clear. Random traffic concentrates on a few mailboxes so that matches, barriers and accumulation occur often.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [1:0] {
        MODE_REPLACE = 2'b00,
        MODE_OR      = 2'b01,
        MODE_ADD     = 2'b10,
        MODE_SPARE   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        COND_DOORBELL = 2'b00,
        COND_MATCH    = 2'b01,
        COND_BARRIER  = 2'b10,
        COND_THRESH   = 2'b11
    } cond_e;

    typedef enum logic [1:0] {
        RGN_DATA = 2'b00,
        RGN_CFG  = 2'b01,
        RGN_TRIG = 2'b10,
        RGN_ACK  = 2'b11
    } region_e;
endpackage

// File: rtl/mbox_combine.sv
module mbox_combine
    import mbox_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  mode_e             mode,
    input  logic [WORD_W-1:0] old_val,
    input  logic [WORD_W-1:0] wr_val,
    output logic [WORD_W-1:0] new_val
);
    always_comb begin
        unique case (mode)
            MODE_OR:  new_val = old_val | wr_val;
            MODE_ADD: new_val = old_val + wr_val;
            default:  new_val = wr_val;
        endcase
    end
endmodule

// File: rtl/mbox_trigger.sv
module mbox_trigger
    import mbox_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  cond_e             cond,
    input  logic [WORD_W-1:0] value,
    input  logic [WORD_W-1:0] level,
    output logic              fire,
    output logic              wipe
);
    logic equal;
    logic at_or_above;

    assign equal       = (value == level);
    assign at_or_above = (value >= level);

    always_comb begin
        unique case (cond)
            COND_DOORBELL: fire = 1'b1;
            COND_MATCH:    fire = equal;
            COND_BARRIER:  fire = equal;
            default:       fire = at_or_above;
        endcase
        wipe = fire && (cond == COND_BARRIER);
    end
endmodule

// File: rtl/mbox_irq_array.sv
module mbox_irq_array
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 128,
    parameter int WORD_W   = 64,
    localparam int IDX_W   = $clog2(NUM_MBOX),
    localparam int ADDR_W  = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    output logic                bus_ready,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data,
    output logic [NUM_MBOX-1:0] irq
);
    logic [WORD_W-1:0] data_q [NUM_MBOX];
    logic [WORD_W-1:0] data_d [NUM_MBOX];
    logic [WORD_W-1:0] lvl_q  [NUM_MBOX];
    logic [WORD_W-1:0] lvl_d  [NUM_MBOX];
    mode_e             mode_q [NUM_MBOX];
    mode_e             mode_d [NUM_MBOX];
    cond_e             cond_q [NUM_MBOX];
    cond_e             cond_d [NUM_MBOX];
    logic [NUM_MBOX-1:0] pend_q, pend_d;
    logic                rdv_q, rdv_d;
    logic [WORD_W-1:0]   rdat_q, rdat_d;

    region_e          region;
    logic [IDX_W-1:0] sel;
    logic [IDX_W-1:0] ack_sel;
    logic             data_wr, cfg_wr, lvl_wr, ack_wr, rd_req;
    logic [WORD_W-1:0] upd_val;
    logic              hit, wipe;

    assign region  = region_e'(bus_addr[ADDR_W-1:IDX_W]);
    assign sel     = bus_addr[IDX_W-1:0];
    assign ack_sel = bus_wdata[IDX_W-1:0];
    assign data_wr = bus_valid && bus_write && (region == RGN_DATA);
    assign cfg_wr  = bus_valid && bus_write && (region == RGN_CFG);
    assign lvl_wr  = bus_valid && bus_write && (region == RGN_TRIG);
    assign ack_wr  = bus_valid && bus_write && (region == RGN_ACK);
    assign rd_req  = bus_valid && !bus_write;

    mbox_combine #(.WORD_W(WORD_W)) u_combine (
        .mode    (mode_q[sel]),
        .old_val (data_q[sel]),
        .wr_val  (bus_wdata),
        .new_val (upd_val)
    );

    mbox_trigger #(.WORD_W(WORD_W)) u_trigger (
        .cond  (cond_q[sel]),
        .value (upd_val),
        .level (lvl_q[sel]),
        .fire  (hit),
        .wipe  (wipe)
    );

    always_comb begin
        data_d = data_q;
        lvl_d  = lvl_q;
        mode_d = mode_q;
        cond_d = cond_q;
        pend_d = pend_q;
        rdv_d  = rd_req;
        rdat_d = rdat_q;

        if (rd_req) begin
            unique case (region)
                RGN_DATA: rdat_d = data_q[sel];
                RGN_CFG:  rdat_d = {{(WORD_W-4){1'b0}}, cond_q[sel], mode_q[sel]};
                RGN_TRIG: rdat_d = lvl_q[sel];
                default:  rdat_d = '0;
            endcase
        end
        if (cfg_wr) begin
            mode_d[sel] = mode_e'(bus_wdata[1:0]);
            cond_d[sel] = cond_e'(bus_wdata[3:2]);
        end
        if (lvl_wr) begin
            lvl_d[sel] = bus_wdata;
        end
        if (ack_wr) begin
            pend_d[ack_sel] = 1'b0;
        end
        if (data_wr) begin
            data_d[sel] = wipe ? '0 : upd_val;
            if (hit) begin
                pend_d[sel] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '{default: '0};
            lvl_q  <= '{default: '0};
            mode_q <= '{default: MODE_REPLACE};
            cond_q <= '{default: COND_DOORBELL};
            pend_q <= '0;
            rdv_q  <= 1'b0;
            rdat_q <= '0;
        end else begin
            data_q <= data_d;
            lvl_q  <= lvl_d;
            mode_q <= mode_d;
            cond_q <= cond_d;
            pend_q <= pend_d;
            rdv_q  <= rdv_d;
            rdat_q <= rdat_d;
        end
    end

    assign bus_ready = 1'b1;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdat_q;
    assign irq       = pend_q;

    AST_RISE_NEEDS_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) != '0) |-> $past(data_wr)) else $error("rise w/o data write"); // R10
    AST_ONE_RISE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend_q & ~$past(pend_q)) <= 1) else $error("multiple rises"); // R10
    AST_ACK_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> !pend_q[$past(ack_sel)]) else $error("ack failed"); // R10
    AST_BARRIER_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && hit && cond_q[sel] == COND_BARRIER) |=> (data_q[$past(sel)] == '0)) else $error("barrier kept value"); // R8
    AST_DOORBELL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cond_q[sel] == COND_DOORBELL) |=> pend_q[$past(sel)]) else $error("doorbell missed"); // R6
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(rd_req)) else $error("read latency"); // R11
endmodule

// File: tb/mbox_irq_array_tb.sv
module mbox_irq_array_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 128;
    localparam int IDX_W = $clog2(N);
    localparam int AW    = IDX_W + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_ready;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic [N-1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] m_data [N];
    logic [63:0] m_lvl  [N];
    logic [1:0]  m_mode [N];
    logic [1:0]  m_cond [N];
    logic [N-1:0] m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_irq_array #(.NUM_MBOX(N), .WORD_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [63:0] f_combine(logic [1:0] md, logic [63:0] o, logic [63:0] w);
        case (md)
            2'b01:   return o | w;
            2'b10:   return o + w;
            default: return w;
        endcase
    endfunction

    function automatic bit f_fire(logic [1:0] cd, logic [63:0] v, logic [63:0] l);
        case (cd)
            2'b00:   return 1'b1;
            2'b01:   return v == l;
            2'b10:   return v == l;
            default: return v >= l;
        endcase
    endfunction

    task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_irq(string req);
        checks++;
        if (irq !== m_irq) begin
            fails++;
            $display("FAIL %s irq: actual %h expected %h", req, irq, m_irq);
        end
    endtask

    task automatic bus_wr(logic [1:0] rgn, int idx, logic [63:0] d, string req);
        logic [63:0] nv;
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr  = {rgn, idx[IDX_W-1:0]}; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        case (rgn)
            2'b00: begin
                nv = f_combine(m_mode[idx], m_data[idx], d);
                if (f_fire(m_cond[idx], nv, m_lvl[idx])) begin
                    m_irq[idx] = 1'b1;
                    if (m_cond[idx] == 2'b10) nv = '0;
                end
                m_data[idx] = nv;
            end
            2'b01: begin m_mode[idx] = d[1:0]; m_cond[idx] = d[3:2]; end
            2'b10: m_lvl[idx] = d;
            default: m_irq[d[IDX_W-1:0]] = 1'b0;
        endcase
        check_irq(req);
    endtask

    task automatic bus_rd(logic [1:0] rgn, int idx, string req);
        logic [63:0] exp;
        bus_valid = 1'b1; bus_write = 1'b0;
        bus_addr  = {rgn, idx[IDX_W-1:0]};
        @(negedge clk);
        bus_valid = 1'b0;
        case (rgn)
            2'b00:   exp = m_data[idx];
            2'b01:   exp = {60'd0, m_cond[idx], m_mode[idx]};
            2'b10:   exp = m_lvl[idx];
            default: exp = '0;
        endcase
        checks++;
        if (rd_valid !== 1'b1) begin
            fails++;
            $display("FAIL R11 rd_valid: actual %b expected 1", rd_valid);
        end
        check64(req, "read", rd_data, exp);
        check_irq(req);
    endtask

    task automatic set_cfg(int idx, logic [1:0] md, logic [1:0] cd, logic [63:0] lvl);
        bus_wr(2'b01, idx, {60'd0, cd, md}, "R10");
        bus_wr(2'b10, idx, lvl, "R10");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < N; i++) begin
            m_data[i] = '0; m_lvl[i] = '0; m_mode[i] = '0; m_cond[i] = '0;
        end
        m_irq = '0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_irq("R1");
        bus_rd(2'b00, 0, "R1");
        bus_rd(2'b01, 127, "R1");
        bus_rd(2'b10, 5, "R1");
        bus_rd(2'b11, 3, "R2");

        // R6 doorbell, R10 ack only clears its own bit
        bus_wr(2'b00, 1, 64'h55, "R6");
        bus_wr(2'b00, 2, 64'h0, "R6");
        bus_wr(2'b11, 0, 64'd1, "R10");
        bus_rd(2'b00, 1, "R3");

        // R4 OR, R5 add wrap
        set_cfg(3, 2'b01, 2'b01, 64'hFF);
        bus_wr(2'b00, 3, 64'h0F, "R4");
        bus_wr(2'b00, 3, 64'hF0, "R4");
        bus_rd(2'b00, 3, "R4");
        set_cfg(4, 2'b10, 2'b01, 64'h1);
        bus_wr(2'b00, 4, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        bus_wr(2'b00, 4, 64'h2, "R5");
        bus_rd(2'b00, 4, "R5");

        // R3 spare mode replaces, R7 match miss then hit
        set_cfg(5, 2'b11, 2'b01, 64'h9);
        bus_wr(2'b00, 5, 64'h7, "R7");
        bus_wr(2'b00, 5, 64'h9, "R7");
        bus_rd(2'b00, 5, "R3");

        // R8 barrier with add, back-to-back accumulation R11
        set_cfg(6, 2'b10, 2'b10, 64'd3);
        bus_wr(2'b00, 6, 64'd1, "R8");
        bus_wr(2'b00, 6, 64'd1, "R11");
        bus_rd(2'b00, 6, "R8");
        bus_wr(2'b00, 6, 64'd1, "R8");
        bus_rd(2'b00, 6, "R8");

        // R9 threshold unsigned
        set_cfg(127, 2'b00, 2'b11, 64'h8000_0000_0000_0000);
        bus_wr(2'b00, 127, 64'h7FFF_FFFF_FFFF_FFFF, "R9");
        bus_wr(2'b00, 127, 64'hFFFF_0000_0000_0000, "R9");
        bus_rd(2'b01, 127, "R2");
        bus_rd(2'b10, 127, "R2");

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int r, idx;
            logic [63:0] d;
            r   = $urandom_range(0, 9);
            idx = ($urandom_range(0, 8) == 8) ? 127 : $urandom_range(0, 7);
            d   = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, 6));
            if (r < 4)       bus_wr(2'b00, idx, d, "R10");
            else if (r == 4) bus_wr(2'b01, idx, 64'($urandom_range(0, 15)), "R10");
            else if (r == 5) bus_wr(2'b10, idx, 64'($urandom_range(0, 6)), "R10");
            else if (r == 6) bus_wr(2'b11, 0, 64'(idx), "R10");
            else             bus_rd(2'($urandom_range(0, 3)), idx, "R11");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule